// File: doc/BRIEF.md
# Synchronous Serial Shifter with Start-Condition Restart

This block moves one word over a clocked serial link. A single 8-bit register serves both directions. The host writes the outgoing word into it and pulses `go`. On every rising edge of the external serial clock, one bit is sampled from `ser_din`. On every falling edge, the register shifts by one place: that sampled bit enters at one end, and the next outgoing bit appears on `ser_dout`. A transfer is 1 to 8 bits long. Bit order is LSB first or MSB first. A short transfer works only inside a window at one end of the register: the upper bits for MSB first, the lower bits for LSB first. When it ends, the received bits sit in the same positions the transmitted ones came from, and the bits outside the window are left unchanged.

Both serial inputs pass through two-flop synchronizers before their edges are detected. The block can optionally watch for a start condition, which is `ser_din` falling while `ser_clk` is high. When start detection is enabled and a start condition arrives during a transfer, the bit count returns to zero, any sampled bit not yet shifted in is discarded, and the transfer carries on from its beginning, using whatever the register holds at that point.

Top module: `serial_shifter`

## Requirements
- R1: After reset, `busy` and `done` are 0 and `data_q` is 0.
- R2: While idle, `wr_en` loads `wr_data` into `data_q`, and `go` sets `busy` on the next cycle and captures `cfg_len` and `cfg_msb_first` for the whole transfer.
- R3: With `cfg_msb_first`=1 and length N, `ser_dout` presents register bits 7, 6, … down to 8−N, one per serial clock period. `cfg_len` is 3 bits wide, and a code of 0 means N=8.
- R4: With `cfg_msb_first`=0 and length N, `ser_dout` presents register bits 0, 1, … up to N−1.
- R5: When a transfer ends, the N received bits occupy the transmit window (upper N bits for MSB first, with the first-received bit at bit 7; lower N bits for LSB first, with the first-received bit at bit 0). Bits outside the window keep their loaded values.
- R6: Input is sampled on the synchronized rising edge of `ser_clk`. `ser_dout` changes only after a synchronized falling edge while busy.
- R7: `done` is high for exactly one cycle, on the falling edge that shifts in the Nth bit, and `busy` is low in that same cycle.
- R8: While `busy` is high, `wr_en` has no effect on `data_q`.
- R9: With `cfg_restart_en`=1, a fall of `ser_din` while `ser_clk` is high during a transfer clears the bit count. N further bits are then required before `done` is raised.
- R10: With `cfg_restart_en`=0, that same line activity leaves the bit count alone, and the transfer ends after N bits in total.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| wr_en | input | 1 | Load `wr_data` into the shift register (idle only) |
| wr_data | input | 8 | Word to transmit |
| go | input | 1 | Begin a transfer (idle only) |
| cfg_len | input | 3 | Bits per transfer, 0 means 8 |
| cfg_msb_first | input | 1 | 1: MSB first, 0: LSB first |
| cfg_restart_en | input | 1 | Enable start-condition restart |
| ser_clk | input | 1 | Serial transfer clock (idles high) |
| ser_din | input | 1 | Serial data in |
| ser_dout | output | 1 | Serial data out |
| busy | output | 1 | Transfer in progress |
| done | output | 1 | One-cycle end-of-transfer pulse |
| data_q | output | 8 | Shift register contents |

## Verification
The hardest case to reach is a start condition that lands inside a transfer. The bench builds it by hand. Part-way through a word, it raises `ser_din` during a low clock phase, lets the clock rise, and then drops `ser_din` while the clock is still high. The same sequence is played once with detection enabled and once with it disabled. The number of bits still needed before `done` tells the two apart. A full sweep of both bit orders, all eight length codes and several data patterns checks the window alignment against masks computed in the bench.

// File: rtl/serial_shifter.sv
module serial_shifter #(
  parameter int W    = 8,
  parameter int SYNC = 2
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 wr_en,
  input  logic [W-1:0]         wr_data,
  input  logic                 go,
  input  logic [$clog2(W)-1:0] cfg_len,
  input  logic                 cfg_msb_first,
  input  logic                 cfg_restart_en,
  input  logic                 ser_clk,
  input  logic                 ser_din,
  output logic                 ser_dout,
  output logic                 busy,
  output logic                 done,
  output logic [W-1:0]         data_q
);
  localparam int LW = $clog2(W);

  logic [SYNC:0] ck_sh, dt_sh;
  logic          ck_now, ck_prev, dt_now, dt_prev;
  logic          ck_rise, ck_fall, st_evt;
  logic [LW-1:0] cnt, len_q, last;
  logic          ord_q, have_bit, rx_q;
  logic [W-1:0]  shifted;
  int            nb;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      ck_sh <= '1;
      dt_sh <= '1;
    end else begin
      ck_sh <= {ck_sh[SYNC-1:0], ser_clk};
      dt_sh <= {dt_sh[SYNC-1:0], ser_din};
    end

  assign ck_now  = ck_sh[SYNC-1];
  assign ck_prev = ck_sh[SYNC];
  assign dt_now  = dt_sh[SYNC-1];
  assign dt_prev = dt_sh[SYNC];
  assign ck_rise = ck_now & ~ck_prev;
  assign ck_fall = ~ck_now & ck_prev;
  assign st_evt  = cfg_restart_en & ck_now & ck_prev & dt_prev & ~dt_now;

  assign last = len_q - 1'b1;
  assign nb   = (len_q == '0) ? W : int'(len_q);

  always_comb begin
    shifted = data_q;
    for (int i = 0; i < W; i++) begin
      if (ord_q) begin
        if (i == W - nb)     shifted[i] = rx_q;
        else if (i > W - nb) shifted[i] = data_q[(i + W - 1) % W];
      end else begin
        if (i == nb - 1)     shifted[i] = rx_q;
        else if (i < nb - 1) shifted[i] = data_q[(i + 1) % W];
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      busy     <= 1'b0;
      done     <= 1'b0;
      data_q   <= '0;
      cnt      <= '0;
      len_q    <= '0;
      ord_q    <= 1'b0;
      have_bit <= 1'b0;
      rx_q     <= 1'b0;
    end else begin
      done <= 1'b0;
      if (!busy) begin
        if (wr_en) data_q <= wr_data;
        if (go) begin
          busy     <= 1'b1;
          cnt      <= '0;
          have_bit <= 1'b0;
          len_q    <= cfg_len;
          ord_q    <= cfg_msb_first;
        end
      end else if (st_evt) begin
        cnt      <= '0;
        have_bit <= 1'b0;
      end else if (ck_rise) begin
        rx_q     <= dt_now;
        have_bit <= 1'b1;
      end else if (ck_fall && have_bit) begin
        data_q   <= shifted;
        have_bit <= 1'b0;
        cnt      <= cnt + 1'b1;
        if (cnt == last) begin
          busy <= 1'b0;
          done <= 1'b1;
        end
      end
    end

  assign ser_dout = (busy ? ord_q : cfg_msb_first) ? data_q[W-1] : data_q[0];
endmodule

// File: rtl/serial_shifter_chk.sv
module serial_shifter_chk #(
  parameter int W = 8
) (
  input logic         clk,
  input logic         rst_n,
  input logic         wr_en,
  input logic         go,
  input logic         busy,
  input logic         done,
  input logic [W-1:0] data_q,
  input logic         ser_dout,
  input logic         ck_fall,
  input logic         st_evt
);
  assert_go_busy_R2: assert property (@(posedge clk) disable iff (!rst_n)
    !busy && go |=> busy);

  assert_dout_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
    busy && !ck_fall |=> $stable(ser_dout));

  assert_done_single_R7: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  assert_done_idle_R7: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> !busy);

  assert_write_blocked_R8: assert property (@(posedge clk) disable iff (!rst_n)
    busy && wr_en && !ck_fall |=> $stable(data_q));

  assert_restart_keeps_busy_R9: assert property (@(posedge clk) disable iff (!rst_n)
    busy && st_evt |=> busy && !done);
endmodule

bind serial_shifter serial_shifter_chk #(.W(W)) chk_i (
  .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .go(go), .busy(busy), .done(done),
  .data_q(data_q), .ser_dout(ser_dout), .ck_fall(ck_fall), .st_evt(st_evt)
);

// File: tb/serial_shifter_tb.sv
module serial_shifter_tb_top;
  localparam int HALF = 8;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       wr_en = 1'b0, go = 1'b0;
  logic [7:0] wr_data = '0;
  logic [2:0] cfg_len = '0;
  logic       cfg_msb_first = 1'b0, cfg_restart_en = 1'b0;
  logic       ser_clk = 1'b1, ser_din = 1'b1;
  logic       ser_dout, busy, done;
  logic [7:0] data_q;

  int n_chk = 0, n_err = 0, done_cnt = 0, done_runs = 0;
  logic done_d = 1'b0;

  always #5 clk = ~clk;

  serial_shifter dut_i (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_data(wr_data), .go(go),
    .cfg_len(cfg_len), .cfg_msb_first(cfg_msb_first), .cfg_restart_en(cfg_restart_en),
    .ser_clk(ser_clk), .ser_din(ser_din), .ser_dout(ser_dout),
    .busy(busy), .done(done), .data_q(data_q)
  );

  always @(posedge clk) begin
    if (done) done_cnt++;
    if (done && done_d) done_runs++;
    done_d <= done;
  end

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic wait_n(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic bit_io(input logic rxb, output logic txb);
    ser_clk = 1'b0;
    wait_n(HALF);
    ser_din = rxb;
    wait_n(HALF);
    txb = ser_dout;
    ser_clk = 1'b1;
    wait_n(HALF);
  endtask

  task automatic tail_fall();
    ser_clk = 1'b0;
    wait_n(HALF);
    ser_clk = 1'b1;
    wait_n(HALF);
  endtask

  task automatic launch(input logic [7:0] d, input logic [2:0] len, input logic msb, input logic en);
    cfg_len = len; cfg_msb_first = msb; cfg_restart_en = en;
    wr_data = d; wr_en = 1'b1; go = 1'b1;
    wait_n(1);
    wr_en = 1'b0; go = 1'b0;
    wait_n(1);
  endtask

  task automatic start_cond_bit();
    ser_clk = 1'b0;
    wait_n(HALF);
    ser_din = 1'b1;
    wait_n(HALF);
    ser_clk = 1'b1;
    wait_n(HALF);
    ser_din = 1'b0;
    wait_n(HALF);
  endtask

  initial begin
    #2000000;
    n_err++;
    $display("FAIL watchdog expired");
    $display("CHECKS %0d ERRORS %0d", n_chk, n_err);
    $finish;
  end

  initial begin
    logic txb;
    int   base;
    wait_n(4);
    rst_n = 1'b1;
    wait_n(2);
    chk("R1 busy", busy, 0);
    chk("R1 done", done, 0);
    chk("R1 data", data_q, 0);

    for (int ord = 0; ord < 2; ord++)
      for (int len = 0; len < 8; len++)
        for (int p = 0; p < 3; p++) begin
          logic [7:0] tx, rxw, mask, exp;
          int n, txerr;
          tx   = 8'hA5 ^ 8'(p * 8'h3C) ^ 8'(len);
          rxw  = {tx[3:0], tx[7:4]} ^ 8'h5A ^ 8'(p * 8'h11);
          n    = (len == 0) ? 8 : len;
          mask = ord ? 8'(8'hFF << (8 - n)) : 8'(8'hFF >> (8 - n));
          exp  = (rxw & mask) | (tx & ~mask);
          txerr = 0;
          base = done_cnt;
          launch(tx, 3'(len), ord[0], 1'b1);
          chk("R2 busy after go", busy, 1);
          chk("R2 loaded", data_q, tx);
          for (int k = 0; k < n; k++) begin
            int idx;
            idx = ord ? 7 - k : k;
            bit_io(rxw[idx], txb);
            if (txb !== tx[idx]) txerr++;
          end
          tail_fall();
          wait_n(4);
          chk(ord ? "R3 msb-first bit errors" : "R4 lsb-first bit errors", txerr, 0);
          chk("R5 window contents", data_q, exp);
          chk("R7 done count", done_cnt - base, 1);
          chk("R7 busy cleared", busy, 0);
        end
    chk("R7 done width one cycle", done_runs, 0);

    begin
      int txerr;
      logic [7:0] tx;
      tx = 8'hC3;
      txerr = 0;
      launch(tx, 3'd4, 1'b0, 1'b0);
      wr_data = 8'h3C; wr_en = 1'b1;
      wait_n(1);
      wr_en = 1'b0;
      wait_n(1);
      chk("R8 write while busy", data_q, 8'hC3);
      for (int k = 0; k < 4; k++) begin
        bit_io(8'h0A >> k, txb);
        if (txb !== tx[k]) txerr++;
      end
      tail_fall();
      wait_n(4);
      chk("R8 transmit unaffected", txerr, 0);
      chk("R8 upper bits kept", data_q, 8'hCA);
    end

    base = done_cnt;
    launch(8'hF0, 3'd0, 1'b1, 1'b1);
    bit_io(1'b0, txb);
    bit_io(1'b0, txb);
    start_cond_bit();
    for (int k = 0; k < 5; k++) bit_io(8'h96 >> (7 - k), txb);
    chk("R9 no done after restart+5", done_cnt - base, 0);
    chk("R9 still busy", busy, 1);
    for (int k = 5; k < 8; k++) bit_io(8'h96 >> (7 - k), txb);
    tail_fall();
    wait_n(4);
    chk("R9 done after 8 post-restart bits", done_cnt - base, 1);
    chk("R9 received word", data_q, 8'h96);

    base = done_cnt;
    launch(8'hF0, 3'd0, 1'b1, 1'b0);
    bit_io(1'b0, txb);
    bit_io(1'b0, txb);
    start_cond_bit();
    for (int k = 0; k < 5; k++) bit_io(1'b1, txb);
    tail_fall();
    wait_n(4);
    chk("R10 done after 8 total bits", done_cnt - base, 1);
    chk("R10 busy cleared", busy, 0);
    chk("R10 received word", data_q, 8'h3F);

    $display("CHECKS %0d ERRORS %0d", n_chk, n_err);
    $finish;
  end
endmodule